// File: doc/BRIEF.md
# Processor Mode and Privilege Controller

This block holds the execution context of a small processor core: whether it is running ordinary code (thread mode) or servicing an exception (handler mode), whether the running code is privileged or restricted to user level, and which of two banked stack pointers is live. The core's sequencer drives an exception-entry strobe, an exception-return strobe and a control-register write port. The block answers with its mode, its privilege and its stack select, and it serves the single stack-pointer read and write port from whichever bank is selected.

The state is kept by a three-state machine. The states are `ST_THR_PRIV` (thread, privileged), `ST_THR_USER` (thread, user level) and `ST_HANDLER`. Each cycle, one classified event drives it:
- `EV_ENTER`: any state goes to `ST_HANDLER`, and the current context is pushed.
- `EV_ENTER_FULL`: no state change; an overflow pulse is raised.
- `EV_RETURN`: `ST_HANDLER` goes to the state held in the popped context.
- `EV_RETURN_BAD`: no state change; an error pulse is raised.
- `EV_CTL_LIVE`: `ST_THR_PRIV` goes to `ST_THR_USER` or stays, and the stack select is updated.
- `EV_CTL_SAVED`: the topmost saved context is rewritten, with no state change.
- `EV_CTL_DENIED`: a write from `ST_THR_USER`, which is dropped.
- `EV_IDLE`: nothing happens.

A small last-in first-out store keeps the context that was interrupted at each nesting level, so that returns unwind in order.

Top module: `mode_priv_ctrl`

## Requirements
- R1: After reset the block is in thread mode and privileged, with the main stack selected (`mode_handler`=0, `priv_level`=1, `sp_sel_psp`=0). Both flags are low and both stack pointers read 0.
- R2: The cycle after `exc_entry` is accepted, the outputs show handler mode (`mode_handler`=1). Privilege reads 1 and the main stack is selected (`sp_sel_psp`=0) for as long as handler mode lasts.
- R3: An accepted `exc_return` restores the mode, privilege and stack select that were current at the matching entry. Nested levels unwind in reverse order.
- R4: In privileged thread mode, a `ctl_we` write sets the privilege from `ctl_user` (1 = user level, 0 = privileged) and the stack select from `ctl_psp_sel` (1 = process stack, 0 = main stack).
- R5: In user-level thread mode, a `ctl_we` write is ignored: neither privilege nor stack select changes.
- R6: In handler mode, a `ctl_we` write rewrites the privilege and stack select of the most recently saved context and leaves the live outputs unchanged. A later return therefore lands at the written level.
- R7: `sp_rdata` shows the selected stack pointer. `sp_we` writes only the stack pointer selected in that cycle.
- R8: Up to 4 nested contexts are saved. An entry while 4 are held raises `overflow_flag` for exactly one cycle and leaves mode, privilege, select and saved contexts unchanged.
- R9: An `exc_return` in thread mode changes nothing and raises `ret_err` for exactly one cycle.
- R10: When `exc_entry` is high, any `ctl_we` or `exc_return` in the same cycle is discarded. No error is raised for the discarded return.
- R11: Stack pointer writes store the data with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ctl_we | input | 1 | Control register write enable |
| ctl_user | input | 1 | Written privilege: 1 user, 0 privileged |
| ctl_psp_sel | input | 1 | Written stack select: 1 process, 0 main |
| sp_we | input | 1 | Stack pointer write enable |
| sp_wdata | input | SP_W | Stack pointer write data |
| sp_rdata | output | SP_W | Selected stack pointer value |
| mode_handler | output | 1 | 1 in handler mode |
| priv_level | output | 1 | 1 when privileged |
| sp_sel_psp | output | 1 | 1 when the process stack is selected |
| overflow_flag | output | 1 | One-cycle pulse: entry refused, save store full |
| ret_err | output | 1 | One-cycle pulse: return refused |

## Verification
Mode, privilege and stack select are registered, so each one changes on the rising edge that samples its strobe or write. The two flags rise on that same edge and fall on the next one. A stack-pointer write becomes visible on `sp_rdata` after its capturing edge. A change of select alters `sp_rdata` in the same cycle that the select changes. The bench applies one stimulus per cycle at a falling edge and lets one rising edge pass. It then compares every output at the following falling edge against a behavioural model written from the requirements, so each pulse is seen in its single cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        ST_THR_PRIV = 2'd0,
        ST_THR_USER = 2'd1,
        ST_HANDLER  = 2'd2
    } pm_state_e;

    typedef enum logic [2:0] {
        EV_IDLE       = 3'd0,
        EV_ENTER      = 3'd1,
        EV_ENTER_FULL = 3'd2,
        EV_RETURN     = 3'd3,
        EV_RETURN_BAD = 3'd4,
        EV_CTL_LIVE   = 3'd5,
        EV_CTL_SAVED  = 3'd6,
        EV_CTL_DENIED = 3'd7
    } pm_event_e;

    typedef struct packed {
        logic handler;
        logic user;
        logic spsel;
    } ctx_t;

endpackage

// File: rtl/pmc_ctx_stack.sv
module pmc_ctx_stack
    import pmc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic wr_top,
    input  ctx_t push_ctx,
    input  logic top_user,
    input  logic top_spsel,
    output ctx_t top_ctx,
    output logic full,
    output logic empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ctx_t           slot [DEPTH];
    logic [CW-1:0]  cnt;
    logic [IW-1:0]  top_idx;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = IW'(cnt - 1'b1);
    assign top_ctx = empty ? '0 : slot[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (push && !full && cnt == CW'(i)) begin
                slot[i] <= push_ctx;
            end else if (wr_top && !empty && top_idx == IW'(i)) begin
                slot[i].user  <= top_user;
                slot[i].spsel <= top_spsel;
            end
        end
    end

endmodule

// File: rtl/pmc_sp_bank.sv
module pmc_sp_bank #(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_psp,
    input  logic            we,
    input  logic [SP_W-1:0] wdata,
    output logic [SP_W-1:0] rdata
);
    localparam logic [SP_W-1:0] ALIGN_MASK = ~(SP_W'(3));

    logic [SP_W-1:0] bank [2];
    logic [SP_W-1:0] aligned;

    assign aligned = wdata & ALIGN_MASK;
    assign rdata   = bank[sel_psp];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[b] <= '0;
            end else if (we && (sel_psp == 1'(b))) begin
                bank[b] <= aligned;
            end
        end
    end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_entry,
    input  logic exc_return,
    input  logic ctl_we,
    input  logic ctl_user,
    input  logic ctl_psp_sel,
    input  logic stk_full,
    input  logic stk_empty,
    input  ctx_t top_ctx,
    output logic push,
    output logic pop,
    output logic wr_top,
    output ctx_t push_ctx,
    output logic mode_handler,
    output logic priv_level,
    output logic sp_sel_psp,
    output logic overflow_flag,
    output logic ret_err
);
    pm_state_e state_q, state_d;
    pm_event_e ev;
    logic      spsel_q, spsel_d;
    logic      ovf_q, err_q;

    // Classify the cycle's request; entry outranks return and writes.
    always_comb begin
        ev = EV_IDLE;
        if (exc_entry) begin
            ev = stk_full ? EV_ENTER_FULL : EV_ENTER;
        end else if (exc_return) begin
            ev = (state_q != ST_HANDLER || stk_empty) ? EV_RETURN_BAD : EV_RETURN;
        end else if (ctl_we) begin
            unique case (state_q)
                ST_THR_PRIV: ev = EV_CTL_LIVE;
                ST_THR_USER: ev = EV_CTL_DENIED;
                ST_HANDLER:  ev = EV_CTL_SAVED;
                default:     ev = EV_IDLE;
            endcase
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        spsel_d = spsel_q;
        unique case (state_q)
            ST_THR_PRIV: begin
                if (ev == EV_ENTER) begin
                    state_d = ST_HANDLER;
                end else if (ev == EV_CTL_LIVE) begin
                    state_d = ctl_user ? ST_THR_USER : ST_THR_PRIV;
                    spsel_d = ctl_psp_sel;
                end
            end
            ST_THR_USER: begin
                if (ev == EV_ENTER) begin
                    state_d = ST_HANDLER;
                end
            end
            ST_HANDLER: begin
                if (ev == EV_RETURN) begin
                    if (top_ctx.handler) begin
                        state_d = ST_HANDLER;
                    end else begin
                        state_d = top_ctx.user ? ST_THR_USER : ST_THR_PRIV;
                    end
                    spsel_d = top_ctx.spsel;
                end
            end
            default: state_d = ST_THR_PRIV;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_THR_PRIV;
            spsel_q <= 1'b0;
            ovf_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            spsel_q <= spsel_d;
            ovf_q   <= (ev == EV_ENTER_FULL);
            err_q   <= (ev == EV_RETURN_BAD);
        end
    end

    // Outputs.
    always_comb begin
        push           = (ev == EV_ENTER);
        pop            = (ev == EV_RETURN);
        wr_top         = (ev == EV_CTL_SAVED);
        push_ctx       = '{handler: (state_q == ST_HANDLER),
                           user:    (state_q == ST_THR_USER),
                           spsel:   spsel_q};
        mode_handler   = 1'b0;
        priv_level     = 1'b1;
        sp_sel_psp     = 1'b0;
        unique case (state_q)
            ST_THR_PRIV: sp_sel_psp = spsel_q;
            ST_THR_USER: begin
                priv_level = 1'b0;
                sp_sel_psp = spsel_q;
            end
            ST_HANDLER:  mode_handler = 1'b1;
            default:     mode_handler = 1'b0;
        endcase
        overflow_flag  = ovf_q;
        ret_err        = err_q;
    end

endmodule

// File: rtl/mode_priv_ctrl.sv
module mode_priv_ctrl
    import pmc_pkg::*;
#(
    parameter int SP_W  = 32,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_entry,
    input  logic            exc_return,
    input  logic            ctl_we,
    input  logic            ctl_user,
    input  logic            ctl_psp_sel,
    input  logic            sp_we,
    input  logic [SP_W-1:0] sp_wdata,
    output logic [SP_W-1:0] sp_rdata,
    output logic            mode_handler,
    output logic            priv_level,
    output logic            sp_sel_psp,
    output logic            overflow_flag,
    output logic            ret_err
);
    logic push, pop, wr_top, stk_full, stk_empty;
    ctx_t push_ctx, top_ctx;

    pmc_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_entry     (exc_entry),
        .exc_return    (exc_return),
        .ctl_we        (ctl_we),
        .ctl_user      (ctl_user),
        .ctl_psp_sel   (ctl_psp_sel),
        .stk_full      (stk_full),
        .stk_empty     (stk_empty),
        .top_ctx       (top_ctx),
        .push          (push),
        .pop           (pop),
        .wr_top        (wr_top),
        .push_ctx      (push_ctx),
        .mode_handler  (mode_handler),
        .priv_level    (priv_level),
        .sp_sel_psp    (sp_sel_psp),
        .overflow_flag (overflow_flag),
        .ret_err       (ret_err)
    );

    pmc_ctx_stack #(.DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .wr_top    (wr_top),
        .push_ctx  (push_ctx),
        .top_user  (ctl_user),
        .top_spsel (ctl_psp_sel),
        .top_ctx   (top_ctx),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    pmc_sp_bank #(.SP_W(SP_W)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_psp (sp_sel_psp),
        .we      (sp_we),
        .wdata   (sp_wdata),
        .rdata   (sp_rdata)
    );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int SP_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_entry,
    input logic            exc_return,
    input logic            mode_handler,
    input logic            priv_level,
    input logic            sp_sel_psp,
    input logic [SP_W-1:0] sp_rdata,
    input logic            overflow_flag,
    input logic            ret_err
);
    AST_HANDLER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        mode_handler |-> priv_level); // R2

    AST_HANDLER_MSP: assert property (@(posedge clk) disable iff (!rst_n)
        mode_handler |-> !sp_sel_psp); // R2

    AST_ENTRY_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (mode_handler || overflow_flag)); // R8

    AST_NO_SELF_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_handler && !priv_level && !exc_entry) |=> !priv_level); // R5

    AST_THREAD_RET_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_entry && !mode_handler) |=> ret_err); // R9

    AST_ENTRY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> !ret_err); // R10

    AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sp_rdata[1:0] == 2'b00); // R11

endmodule

bind mode_priv_ctrl pmc_checker #(.SP_W(SP_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_entry     (exc_entry),
    .exc_return    (exc_return),
    .mode_handler  (mode_handler),
    .priv_level    (priv_level),
    .sp_sel_psp    (sp_sel_psp),
    .sp_rdata      (sp_rdata),
    .overflow_flag (overflow_flag),
    .ret_err       (ret_err)
);

// File: tb/tb_mode_priv_ctrl.sv
module tb_mode_priv_ctrl;
    localparam int SP_W = 32;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            exc_entry = 1'b0, exc_return = 1'b0, ctl_we = 1'b0;
    logic            ctl_user = 1'b0, ctl_psp_sel = 1'b0, sp_we = 1'b0;
    logic [SP_W-1:0] sp_wdata = '0;
    logic [SP_W-1:0] sp_rdata;
    logic            mode_handler, priv_level, sp_sel_psp, overflow_flag, ret_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state, from the requirements
    bit              m_h, m_u, m_s;
    bit              s_h [DEPTH];
    bit              s_u [DEPTH];
    bit              s_s [DEPTH];
    int              m_cnt;
    logic [SP_W-1:0] m_msp, m_psp;
    bit              e_ovf, e_err;

    always #5 clk = ~clk;

    mode_priv_ctrl #(.SP_W(SP_W), .DEPTH(DEPTH)) dut (.*);

    task automatic check(input string tag);
        logic [SP_W+4:0] act, exp;
        act = {mode_handler, priv_level, sp_sel_psp, overflow_flag, ret_err, sp_rdata};
        exp = {m_h, (m_h | ~m_u), (~m_h & m_s), e_ovf, e_err, (m_h ? m_msp : (m_s ? m_psp : m_msp))};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {mode,priv,psp,ovf,err,sp} actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_h = 0; m_u = 0; m_s = 0; m_cnt = 0; m_msp = '0; m_psp = '0;
        e_ovf = 0; e_err = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Assumes the caller is at a falling edge.
    task automatic step(input bit en, input bit rt, input bit we, input bit cu, input bit cs,
                        input bit spw, input logic [SP_W-1:0] spd, input string tag);
        bit sel;
        exc_entry = en; exc_return = rt; ctl_we = we; ctl_user = cu; ctl_psp_sel = cs;
        sp_we = spw; sp_wdata = spd;
        @(posedge clk);
        sel = m_h ? 1'b0 : m_s;
        if (spw) begin
            if (sel) m_psp = spd & ~(SP_W'(3));
            else     m_msp = spd & ~(SP_W'(3));
        end
        e_ovf = 0; e_err = 0;
        if (en) begin
            if (m_cnt == DEPTH) e_ovf = 1;
            else begin
                s_h[m_cnt] = m_h; s_u[m_cnt] = m_u; s_s[m_cnt] = m_s;
                m_cnt++; m_h = 1;
            end
        end else if (rt) begin
            if (!m_h || m_cnt == 0) e_err = 1;
            else begin
                m_cnt--; m_h = s_h[m_cnt]; m_u = s_u[m_cnt]; m_s = s_s[m_cnt];
            end
        end else if (we) begin
            if (m_h) begin
                s_u[m_cnt-1] = cu; s_s[m_cnt-1] = cs;
            end else if (!m_u) begin
                m_u = cu; m_s = cs;
            end
        end
        @(negedge clk);
        exc_entry = 0; exc_return = 0; ctl_we = 0; sp_we = 0;
        check(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset state");
        step(0,0,0,0,0,0,'0,"R1 idle after reset");

        // R11: alignment sweep on the main stack pointer
        for (int i = 0; i < 16; i++) begin
            step(0,0,0,0,0,1, SP_W'(32'h2000_0000 + i*37), "R11 aligned write");
        end

        // R4, R5, R7: every start level and select against every write value
        for (int st = 0; st < 4; st++) begin
            for (int wv = 0; wv < 4; wv++) begin
                do_reset();
                step(0,0,1, st[1], st[0], 0,'0, "R4 set start level");
                step(0,0,0,0,0,1, SP_W'(32'h100 + st*16 + wv), "R7 write selected");
                step(0,0,1, wv[1], wv[0], 0,'0, st[1] ? "R5 user write ignored" : "R4 privileged write");
                step(0,0,0,0,0,1, SP_W'(32'h8000 + wv*4 + 3), "R7 write after select");
            end
        end

        // R2, R3, R8, R9, R7: nesting to full depth from user thread on process stack
        do_reset();
        step(0,0,1,1,1,0,'0,"R4 go user psp");
        step(0,0,0,0,0,1,32'h0000_4444,"R7 psp write");
        step(0,1,0,0,0,0,'0,"R9 return in thread");
        for (int d = 0; d < DEPTH; d++) begin
            step(1,0,0,0,0,1, SP_W'(32'h9000 + d*8), "R2 nested entry");
        end
        step(1,0,0,0,0,0,'0,"R8 overflow entry");
        step(0,0,0,0,0,0,'0,"R8 overflow pulse ends");
        for (int d = 0; d < DEPTH; d++) begin
            step(0,1,0,0,0,0,'0,"R3 nested return");
        end
        step(0,1,0,0,0,0,'0,"R9 return with nothing saved");
        step(0,0,0,0,0,0,'0,"R9 error pulse ends");

        // R6: handler lifts the saved level of the interrupted thread
        step(1,0,0,0,0,0,'0,"R2 entry from user");
        step(0,0,1,0,0,0,'0,"R6 handler write to saved");
        step(0,1,0,0,0,0,'0,"R6 return lands privileged");
        // R6 sweep over nested levels and values
        for (int v = 0; v < 4; v++) begin
            step(1,0,0,0,0,0,'0,"R2 entry level one");
            step(1,0,0,0,0,0,'0,"R2 entry level two");
            step(0,0,1,v[1],v[0],0,'0,"R6 write saved handler ctx");
            step(0,1,0,0,0,0,'0,"R3 return to handler");
            step(0,0,1,v[0],v[1],0,'0,"R6 write saved thread ctx");
            step(0,1,0,0,0,0,'0,"R6 return to thread");
            if (m_u) begin
                step(1,0,0,0,0,0,'0,"R2 recover entry");
                step(0,0,1,0,0,0,'0,"R6 recover write");
                step(0,1,0,0,0,0,'0,"R6 recover return");
            end
        end

        // R10: entry beats a write and a return in the same cycle
        do_reset();
        step(1,0,1,1,1,0,'0,"R10 entry with write");
        step(0,1,0,0,0,0,'0,"R10 write was discarded");
        step(1,1,0,0,0,0,'0,"R10 entry with return in thread");
        step(1,1,1,1,1,0,'0,"R10 entry with return in handler");
        step(0,1,0,0,0,0,'0,"R3 unwind one");
        step(0,1,0,0,0,0,'0,"R3 unwind two");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule